// File: doc/BRIEF.md
# Display Controller Shadowed Register Bank

This block is the programming interface of a display controller. A host reaches it over a simple 32-bit memory-mapped bus. Through it the host sets the panel size of the LCD and digital outputs, the graphics layer (two base addresses, position, size, row and pixel increments), the background and transparency colours, and the horizontal and vertical timing words. It also holds the interrupt status and enable registers, and it drives one level-sensitive interrupt line.

Layer, size, colour and timing writes land in shadow copies. Reads return these shadow copies. The values that the display pipeline actually uses are the active copies, which appear on dedicated output ports. The host requests a commit by setting a per-output go bit in the control register. The go bit stays set until the next frame-start pulse for that output. On that pulse the active copies of that output's group are loaded from the shadows and the go bit clears itself. The digital output group holds only the digital size register. Every other shadowed register belongs to the LCD group.

Top module: `dsc_regbank`

## Requirements
- R1: `irq_o` is high exactly when some bit is set in both the status register and the enable register. It follows any change of either register with no added register stage.
- R2: The status register sits at offset 0x08. A rising `irq_src_i` bit sets the matching status bit. A write clears each bit written as 1 and leaves the other bits unchanged. When a source bit and a clear of the same bit arrive in the same cycle, the source wins and the bit stays set.
- R3: The enable register sits at offset 0x0C and keeps only bits 15:0. A read returns zero in bits 31:16.
- R4: The size registers use bits 10:0 for width minus one and bits 26:16 for height minus one, and read back in the same encoding. The graphics position register uses the same fields for X and Y, with no offset. All other bits read 0.
- R5: The background and transparency colour registers keep bits 23:0. Both timing registers keep only the bits set in 0x0FF0FF3F.
- R6: The control register sits at offset 0x10. Bit 0 drives `lcd_en_o` and bit 1 drives `dig_en_o`, from the cycle after the write. Control bits other than 0, 1, 5 and 6 read as 0.
- R7: Writing 1 to control bit 5 (LCD go) or bit 6 (digital go) makes that bit read 1 while the commit is pending. The active outputs of the group keep their values until a frame-start pulse arrives for that output with the commit pending. After that pulse the active outputs equal the shadow copies and the go bit reads 0. A frame-start pulse with no commit pending changes nothing.
- R8: Each shadowed register i sits at offset 0x40 + 4*i, in this order: horizontal timing, vertical timing, LCD size, digital size, background colour, transparency colour, base 0, base 1, position, graphics size, row increment, pixel increment. A read returns the shadow copy, which is the last masked value written.
- R9: A write to offset 0x00 with bit 1 set returns every register, shadow and active copy, pending go bit and interrupt register to its reset value in the same cycle. A read of offset 0x04 always returns 1.
- R10: After reset, all size fields are 0 (meaning 1x1), the row and pixel increments are 1, and every other register and active output is 0.
- R11: `ready_o` is high in the cycle after each request and carries the read data in that cycle. Reads of unmapped offsets return 0, and writes to them change nothing.
- R12: A commit on one output does not move the active copies of the other output's group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Response, one cycle after req_i |
| frame_lcd_i | input | 1 | LCD frame-start pulse |
| frame_dig_i | input | 1 | Digital output frame-start pulse |
| irq_src_i | input | IRQ_W | Interrupt event pulses |
| irq_o | output | 1 | Level interrupt |
| lcd_en_o | output | 1 | LCD output enable |
| dig_en_o | output | 1 | Digital output enable |
| act_tim_h_o | output | 32 | Active horizontal timing |
| act_tim_v_o | output | 32 | Active vertical timing |
| act_lcd_size_o | output | 32 | Active LCD size |
| act_dig_size_o | output | 32 | Active digital size |
| act_bg_o | output | 24 | Active background colour |
| act_trans_o | output | 24 | Active transparency colour |
| act_gfx_ba0_o | output | 32 | Active graphics base 0 |
| act_gfx_ba1_o | output | 32 | Active graphics base 1 |
| act_gfx_pos_o | output | 32 | Active graphics position |
| act_gfx_size_o | output | 32 | Active graphics size |
| act_gfx_rowinc_o | output | 32 | Active row increment |
| act_gfx_pixinc_o | output | 32 | Active pixel increment |

## Verification
Two situations are hard to reach from the ports. The first is a commit pending on one output while the frame-start pulse of the other output arrives. The stimulus reaches it by pulsing the wrong output's frame input first and checking that both the go bit and the active values hold. The second is a status bit that is set and cleared in the same cycle. The stimulus reaches it by driving an interrupt source together with a clearing status write. Random register writes, interleaved with random go requests and frame pulses, then compare every active output against a bench model after each step.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int N_SREG = 12;
  localparam int N_OUT  = 2;
  localparam int OUT_LCD = 0;
  localparam int OUT_DIG = 1;

  localparam logic [7:0] OFS_SYSCFG    = 8'h00;
  localparam logic [7:0] OFS_SYSSTAT   = 8'h04;
  localparam logic [7:0] OFS_IRQ_ST    = 8'h08;
  localparam logic [7:0] OFS_IRQ_EN    = 8'h0C;
  localparam logic [7:0] OFS_CTRL      = 8'h10;
  localparam logic [7:0] OFS_SREG_BASE = 8'h40;

  localparam int CTRL_LCD_EN = 0;
  localparam int CTRL_DIG_EN = 1;
  localparam int CTRL_GO_LCD = 5;
  localparam int CTRL_GO_DIG = 6;
  localparam int SYSCFG_SRST = 1;

  localparam int SR_TIM_H    = 0;
  localparam int SR_TIM_V    = 1;
  localparam int SR_LCD_SIZE = 2;
  localparam int SR_DIG_SIZE = 3;
  localparam int SR_BG       = 4;
  localparam int SR_TRANS    = 5;
  localparam int SR_GFX_BA0  = 6;
  localparam int SR_GFX_BA1  = 7;
  localparam int SR_GFX_POS  = 8;
  localparam int SR_GFX_SIZE = 9;
  localparam int SR_ROWINC   = 10;
  localparam int SR_PIXINC   = 11;

  function automatic logic [31:0] sreg_mask(int i);
    case (i)
      SR_TIM_H, SR_TIM_V:                           return 32'h0FF0FF3F;
      SR_LCD_SIZE, SR_DIG_SIZE, SR_GFX_POS, SR_GFX_SIZE: return 32'h07FF07FF;
      SR_BG, SR_TRANS:                              return 32'h00FFFFFF;
      default:                                      return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] sreg_rst(int i);
    return (i == SR_ROWINC || i == SR_PIXINC) ? 32'd1 : 32'd0;
  endfunction

  function automatic int sreg_out(int i);
    return (i == SR_DIG_SIZE) ? OUT_DIG : OUT_LCD;
  endfunction

  function automatic int go_bit(int o);
    return (o == OUT_DIG) ? CTRL_GO_DIG : CTRL_GO_LCD;
  endfunction
endpackage

// File: rtl/dsc_shadow_reg.sv
module dsc_shadow_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= RST;
      active_o <= RST;
    end else if (soft_rst_i) begin
      shadow_o <= RST;
      active_o <= RST;
    end else begin
      if (wr_i)     shadow_o <= wdata_i & MASK;
      // old shadow is taken when a write and a commit meet
      if (commit_i) active_o <= shadow_o;
    end
  end
endmodule

// File: rtl/dsc_go_ctrl.sv
module dsc_go_ctrl #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic [N-1:0] go_set_i,
  input  logic [N-1:0] frame_i,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] commit_o
);
  for (genvar o = 0; o < N; o++) begin : g_out
    assign commit_o[o] = pending_o[o] & frame_i[o];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pending_o[o] <= 1'b0;
      else if (soft_rst_i)  pending_o[o] <= 1'b0;
      else if (go_set_i[o]) pending_o[o] <= 1'b1;
      else if (frame_i[o])  pending_o[o] <= 1'b0;
    end
  end
endmodule

// File: rtl/dsc_irq.sv
module dsc_irq #(
  parameter int IRQ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             clr_wr_i,
  input  logic             en_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] status_o,
  output logic [IRQ_W-1:0] enable_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] clr_mask;
  assign clr_mask = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
    end else if (soft_rst_i) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      status_o <= (status_o & ~clr_mask) | set_i;
      if (en_wr_i) enable_o <= wdata_i;
    end
  end

  assign irq_o = |(status_o & enable_o);
endmodule

// File: rtl/dsc_regbank.sv
module dsc_regbank
  import dsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  input  logic              frame_lcd_i,
  input  logic              frame_dig_i,
  input  logic [IRQ_W-1:0]  irq_src_i,
  output logic              irq_o,
  output logic              lcd_en_o,
  output logic              dig_en_o,
  output logic [31:0]       act_tim_h_o,
  output logic [31:0]       act_tim_v_o,
  output logic [31:0]       act_lcd_size_o,
  output logic [31:0]       act_dig_size_o,
  output logic [23:0]       act_bg_o,
  output logic [23:0]       act_trans_o,
  output logic [31:0]       act_gfx_ba0_o,
  output logic [31:0]       act_gfx_ba1_o,
  output logic [31:0]       act_gfx_pos_o,
  output logic [31:0]       act_gfx_size_o,
  output logic [31:0]       act_gfx_rowinc_o,
  output logic [31:0]       act_gfx_pixinc_o
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int SREG_WORD = int'(OFS_SREG_BASE) / 4;

  logic [WORD_W-1:0] word;
  logic              wr, rd;
  logic              soft_rst, ctrl_wr, st_wr, en_wr;
  logic [N_SREG-1:0] sreg_wr;
  logic [N_OUT-1:0]  go_set, frame, go_pend, commit;
  logic [31:0]       shadow_q [N_SREG];
  logic [31:0]       active_q [N_SREG];
  logic [IRQ_W-1:0]  irq_st, irq_en;
  logic [31:0]       rd_val;

  assign word = addr_i[ADDR_W-1:2];
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;

  function automatic logic at(logic [WORD_W-1:0] w, logic [7:0] ofs);
    return w == WORD_W'(ofs[7:2]);
  endfunction

  assign soft_rst = wr && at(word, OFS_SYSCFG) && wdata_i[SYSCFG_SRST];
  assign ctrl_wr  = wr && at(word, OFS_CTRL);
  assign st_wr    = wr && at(word, OFS_IRQ_ST);
  assign en_wr    = wr && at(word, OFS_IRQ_EN);

  assign frame = {frame_dig_i, frame_lcd_i};
  for (genvar o = 0; o < N_OUT; o++) begin : g_go
    assign go_set[o] = ctrl_wr & wdata_i[go_bit(o)];
  end

  dsc_go_ctrl #(.N(N_OUT)) u_go (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .go_set_i   (go_set),
    .frame_i    (frame),
    .pending_o  (go_pend),
    .commit_o   (commit)
  );

  for (genvar g = 0; g < N_SREG; g++) begin : g_sreg
    assign sreg_wr[g] = wr && (word == WORD_W'(SREG_WORD + g));
    dsc_shadow_reg #(
      .W    (32),
      .MASK (sreg_mask(g)),
      .RST  (sreg_rst(g))
    ) u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_i       (sreg_wr[g]),
      .wdata_i    (wdata_i),
      .commit_i   (commit[sreg_out(g)]),
      .shadow_o   (shadow_q[g]),
      .active_o   (active_q[g])
    );
  end

  dsc_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .set_i      (irq_src_i),
    .clr_wr_i   (st_wr),
    .en_wr_i    (en_wr),
    .wdata_i    (wdata_i[IRQ_W-1:0]),
    .status_o   (irq_st),
    .enable_o   (irq_en),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcd_en_o <= 1'b0;
      dig_en_o <= 1'b0;
    end else if (soft_rst) begin
      lcd_en_o <= 1'b0;
      dig_en_o <= 1'b0;
    end else if (ctrl_wr) begin
      lcd_en_o <= wdata_i[CTRL_LCD_EN];
      dig_en_o <= wdata_i[CTRL_DIG_EN];
    end
  end

  always_comb begin
    rd_val = '0;
    if (at(word, OFS_SYSSTAT))     rd_val = 32'd1;
    else if (at(word, OFS_IRQ_ST)) rd_val = 32'(irq_st);
    else if (at(word, OFS_IRQ_EN)) rd_val = 32'(irq_en);
    else if (at(word, OFS_CTRL)) begin
      rd_val[CTRL_LCD_EN] = lcd_en_o;
      rd_val[CTRL_DIG_EN] = dig_en_o;
      rd_val[CTRL_GO_LCD] = go_pend[OUT_LCD];
      rd_val[CTRL_GO_DIG] = go_pend[OUT_DIG];
    end else begin
      for (int i = 0; i < N_SREG; i++)
        if (word == WORD_W'(SREG_WORD + i)) rd_val = shadow_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      ready_o <= 1'b0;
    end else begin
      rdata_o <= rd ? rd_val : '0;
      ready_o <= req_i;
    end
  end

  assign act_tim_h_o      = active_q[SR_TIM_H];
  assign act_tim_v_o      = active_q[SR_TIM_V];
  assign act_lcd_size_o   = active_q[SR_LCD_SIZE];
  assign act_dig_size_o   = active_q[SR_DIG_SIZE];
  assign act_bg_o         = active_q[SR_BG][23:0];
  assign act_trans_o      = active_q[SR_TRANS][23:0];
  assign act_gfx_ba0_o    = active_q[SR_GFX_BA0];
  assign act_gfx_ba1_o    = active_q[SR_GFX_BA1];
  assign act_gfx_pos_o    = active_q[SR_GFX_POS];
  assign act_gfx_size_o   = active_q[SR_GFX_SIZE];
  assign act_gfx_rowinc_o = active_q[SR_ROWINC];
  assign act_gfx_pixinc_o = active_q[SR_PIXINC];

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], active_q[SR_BG][31:24], active_q[SR_TRANS][31:24]};
endmodule

// File: rtl/dsc_regbank_chk.sv
module dsc_regbank_chk
  import dsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IRQ_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [IRQ_W-1:0]  irq_src_i,
  input logic              frame_lcd_i,
  input logic              frame_dig_i,
  input logic              ready_o,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [IRQ_W-1:0]  irq_st_i,
  input logic [IRQ_W-1:0]  irq_en_i,
  input logic [1:0]        go_pend_i,
  input logic              soft_rst_i,
  input logic [31:0]       act_lcd_size_i,
  input logic [31:0]       act_dig_size_i,
  input logic [31:0]       shd_lcd_size_i
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] w;
  assign w = addr_i[ADDR_W-1:2];

  logic wr_st, wr_en, wr_go_lcd, rd_stat;
  assign wr_st     = req_i && we_i && w == WORD_W'(OFS_IRQ_ST[7:2]);
  assign wr_en     = req_i && we_i && w == WORD_W'(OFS_IRQ_EN[7:2]);
  assign wr_go_lcd = req_i && we_i && w == WORD_W'(OFS_CTRL[7:2]) && wdata_i[CTRL_GO_LCD];
  assign rd_stat   = req_i && !we_i && w == WORD_W'(OFS_SYSSTAT[7:2]);

  assert_irq_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_src_i != '0 || wr_en));

  assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st |=> ((irq_st_i & $past(wdata_i[IRQ_W-1:0] & ~irq_src_i)) == '0));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_st && !soft_rst_i) |=> ((irq_st_i & $past(irq_st_i)) == $past(irq_st_i)));

  assert_en_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !soft_rst_i) |=> irq_en_i == $past(wdata_i[IRQ_W-1:0]));

  assert_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_pend_i[0] && frame_lcd_i && !wr_go_lcd && !soft_rst_i)
      |=> (!go_pend_i[0] && act_lcd_size_i == $past(shd_lcd_size_i)));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(go_pend_i[0] && frame_lcd_i) && !soft_rst_i) |=> $stable(act_lcd_size_i));

  assert_dig_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(go_pend_i[1] && frame_dig_i) && !soft_rst_i) |=> $stable(act_dig_size_i));

  assert_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);

  assert_sysstat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> rdata_o == 32'd1);

  logic unused_bits;
  assign unused_bits = ^addr_i[1:0];
endmodule

bind dsc_regbank dsc_regbank_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .irq_src_i      (irq_src_i),
  .frame_lcd_i    (frame_lcd_i),
  .frame_dig_i    (frame_dig_i),
  .ready_o        (ready_o),
  .rdata_o        (rdata_o),
  .irq_o          (irq_o),
  .irq_st_i       (irq_st),
  .irq_en_i       (irq_en),
  .go_pend_i      (go_pend),
  .soft_rst_i     (soft_rst),
  .act_lcd_size_i (active_q[2]),
  .act_dig_size_i (active_q[3]),
  .shd_lcd_size_i (shadow_q[2])
);

// File: tb/tb_dsc_regbank.sv
`timescale 1ns/1ps
module tb_dsc_regbank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        frame_lcd = 1'b0, frame_dig = 1'b0;
  logic [15:0] irq_src = '0;
  logic [31:0] rdata;
  logic        ready, irq, lcd_en, dig_en;
  logic [31:0] a_th, a_tv, a_ls, a_ds, a_b0, a_b1, a_pos, a_gs, a_ri, a_pi;
  logic [23:0] a_bg, a_tr;

  always #2.5 clk = ~clk;

  dsc_regbank dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .frame_lcd_i(frame_lcd), .frame_dig_i(frame_dig), .irq_src_i(irq_src),
    .irq_o(irq), .lcd_en_o(lcd_en), .dig_en_o(dig_en),
    .act_tim_h_o(a_th), .act_tim_v_o(a_tv), .act_lcd_size_o(a_ls),
    .act_dig_size_o(a_ds), .act_bg_o(a_bg), .act_trans_o(a_tr),
    .act_gfx_ba0_o(a_b0), .act_gfx_ba1_o(a_b1), .act_gfx_pos_o(a_pos),
    .act_gfx_size_o(a_gs), .act_gfx_rowinc_o(a_ri), .act_gfx_pixinc_o(a_pi)
  );

  localparam logic [7:0] A_SYSCFG = 8'h00, A_SYSSTAT = 8'h04, A_ST = 8'h08,
                         A_EN = 8'h0C, A_CTRL = 8'h10, A_SBASE = 8'h40;

  int n_tests = 0, n_fail = 0;
  logic [31:0] sh [12];
  logic [31:0] am [12];
  logic        pend_l = 1'b0, pend_d = 1'b0;
  logic [31:0] last_rd;
  logic        last_rdy;
  logic [15:0] m_st = '0, m_en = '0;

  function automatic logic [31:0] m_mask(int i);
    case (i)
      0, 1:       return 32'h0FF0FF3F;
      2, 3, 8, 9: return 32'h07FF07FF;
      4, 5:       return 32'h00FFFFFF;
      default:    return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] m_rst(int i);
    return (i == 10 || i == 11) ? 32'd1 : 32'd0;
  endfunction

  function automatic logic [31:0] act_port(int i);
    case (i)
      0: return a_th;  1: return a_tv;  2: return a_ls;  3: return a_ds;
      4: return {8'h0, a_bg}; 5: return {8'h0, a_tr};
      6: return a_b0;  7: return a_b1;  8: return a_pos; 9: return a_gs;
      10: return a_ri; default: return a_pi;
    endcase
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus(logic w, logic [7:0] a, logic [31:0] d, logic [15:0] src);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; irq_src = src;
    @(negedge clk);
    req = 1'b0; we = 1'b0; irq_src = '0;
    last_rd = rdata; last_rdy = ready;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus(1'b1, a, d, '0);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus(1'b0, a, '0, '0);
    d = last_rd;
  endtask

  task automatic wr_sreg(int i, logic [31:0] d);
    wr(A_SBASE + 8'(4 * i), d);
    sh[i] = d & m_mask(i);
  endtask

  task automatic go(logic gl, logic gd, logic el, logic ed);
    wr(A_CTRL, {25'h0, gd, gl, 3'b000, ed, el});
    pend_l |= gl; pend_d |= gd;
  endtask

  task automatic frame(logic fl, logic fd);
    @(negedge clk);
    frame_lcd = fl; frame_dig = fd;
    @(negedge clk);
    frame_lcd = 1'b0; frame_dig = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (i == 3 && fd && pend_d) am[i] = sh[i];
      if (i != 3 && fl && pend_l) am[i] = sh[i];
    end
    if (fl) pend_l = 1'b0;
    if (fd) pend_d = 1'b0;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    for (int i = 0; i < 12; i++) begin
      check(tag, act_port(i), am[i]);
      rd(A_SBASE + 8'(4 * i), v);
      check(tag, v, sh[i]);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 12; i++) begin sh[i] = m_rst(i); am[i] = m_rst(i); end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    check("R10 irq", {31'h0, irq}, 0);
    check("R10 lcd_en", {31'h0, lcd_en}, 0);
    check_all("R10 reset value");
    rd(A_CTRL, v); check("R10 ctrl", v, 0);
    check("R11 ready after read", {31'h0, last_rdy}, 1);
    @(negedge clk);
    check("R11 ready idle", {31'h0, ready}, 0);
    rd(A_SYSSTAT, v); check("R9 sysstat", v, 1);

    // R11 unmapped
    rd(8'h20, v); check("R11 unmapped read", v, 0);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'hFC, 32'hFFFFFFFF);
    rd(A_CTRL, v); check("R11 unmapped write ctrl", v, 0);
    rd(A_EN, v); check("R11 unmapped write en", v, 0);
    check_all("R11 unmapped write sregs");

    // R3 / R4 / R5 masks
    wr(A_EN, 32'hFFFFFFFF); rd(A_EN, v); check("R3 enable mask", v, 32'h0000FFFF);
    wr(A_EN, 32'h0);
    wr_sreg(0, 32'hFFFFFFFF); rd(A_SBASE, v); check("R5 timing mask", v, 32'h0FF0FF3F);
    wr_sreg(4, 32'hFFFFFFFF); rd(A_SBASE + 8'd16, v); check("R5 colour mask", v, 32'h00FFFFFF);
    wr_sreg(9, 32'hFFFFFFFF); rd(A_SBASE + 8'd36, v); check("R4 size mask", v, 32'h07FF07FF);
    wr_sreg(8, 32'h00C8_0064); rd(A_SBASE + 8'd32, v); check("R4 position", v, 32'h00C80064);

    // R6 / R7 / R8 / R12 directed commit
    wr_sreg(2, 32'h00EF_013F);
    rd(A_SBASE + 8'd8, v); check("R8 shadow read", v, 32'h00EF013F);
    check("R7 active held", a_ls, 0);
    go(1'b1, 1'b0, 1'b1, 1'b0);
    check("R6 lcd_en", {31'h0, lcd_en}, 1);
    check("R6 dig_en", {31'h0, dig_en}, 0);
    rd(A_CTRL, v); check("R7 go pending", v, 32'h21);
    frame(1'b0, 1'b1);
    check("R12 wrong frame holds lcd", a_ls, 0);
    rd(A_CTRL, v); check("R12 go still pending", v, 32'h21);
    frame(1'b1, 1'b0);
    check("R7 committed lcd size", a_ls, 32'h00EF013F);
    check("R7 committed gfx size", a_gs, 32'h07FF07FF);
    rd(A_CTRL, v); check("R7 go self-clear", v, 32'h01);
    wr_sreg(3, 32'h01DF_027F);
    go(1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 dig_en", {31'h0, dig_en}, 1);
    frame(1'b1, 1'b0);
    check("R12 lcd frame holds dig", a_ds, 0);
    frame(1'b0, 1'b1);
    check("R7 committed dig size", a_ds, 32'h01DF027F);
    wr_sreg(2, 32'h1);
    frame(1'b1, 1'b0);
    check("R7 frame without go", a_ls, 32'h00EF013F);
    check_all("R8 after directed");

    // R1 / R2 directed
    wr(A_EN, 32'h0005);
    bus(1'b1, A_ST, 0, 16'h0003);
    check("R1 irq set", {31'h0, irq}, 1);
    rd(A_ST, v); check("R2 status set", v, 3);
    wr(A_ST, 32'h0001);
    rd(A_ST, v); check("R2 w1c keeps others", v, 2);
    check("R1 irq masked", {31'h0, irq}, 0);
    bus(1'b1, A_ST, 32'h0002, 16'h0002);
    rd(A_ST, v); check("R2 set wins over clear", v, 2);
    bus(1'b1, A_ST, 32'h0002, 16'h0004);
    rd(A_ST, v); check("R2 clear and set other", v, 4);
    check("R1 irq enabled bit", {31'h0, irq}, 1);
    m_st = 16'h0004; m_en = 16'h0005;

    // random registers and commits
    for (int k = 0; k < 40; k++) begin
      int i;
      i = $urandom_range(0, 11);
      wr_sreg(i, $urandom);
      if ($urandom_range(0, 3) == 0) go(1'($urandom), 1'($urandom), 1'b1, 1'b1);
      if ($urandom_range(0, 2) == 0) frame(1'($urandom), 1'($urandom));
      for (int j = 0; j < 12; j++) check("R7 random active", act_port(j), am[j]);
      i = $urandom_range(0, 11);
      rd(A_SBASE + 8'(4 * i), v); check("R8 random shadow", v, sh[i]);
    end

    // random interrupts
    for (int k = 0; k < 40; k++) begin
      logic [15:0] src, d;
      src = 16'($urandom) & 16'($urandom);
      d = 16'($urandom);
      case ($urandom_range(0, 2))
        0: begin bus(1'b1, A_ST, {16'h0, d}, src); m_st = (m_st & ~d) | src; end
        1: begin bus(1'b1, A_EN, {16'hFFFF, d}, src); m_en = d; m_st |= src; end
        default: begin bus(1'b0, A_CTRL, 0, src); m_st |= src; end
      endcase
      check("R1 random irq", {31'h0, irq}, {31'h0, |(m_st & m_en)});
      rd(A_ST, v); check("R2 random status", v, {16'h0, m_st});
    end

    // R9 soft reset
    bus(1'b1, A_EN, 32'hFFFF, 16'hFFFF);
    check("R9 pre irq", {31'h0, irq}, 1);
    go(1'b1, 1'b1, 1'b1, 1'b1);
    wr(A_SYSCFG, 32'h2);
    check("R9 irq cleared", {31'h0, irq}, 0);
    check("R9 lcd_en cleared", {31'h0, lcd_en}, 0);
    rd(A_CTRL, v); check("R9 ctrl", v, 0);
    rd(A_EN, v); check("R9 enable", v, 0);
    rd(A_ST, v); check("R9 status", v, 0);
    for (int i = 0; i < 12; i++) begin sh[i] = m_rst(i); am[i] = m_rst(i); end
    pend_l = 1'b0; pend_d = 1'b0;
    check_all("R9 soft reset values");
    rd(A_SYSSTAT, v); check("R9 sysstat after", v, 1);

    finish_run();
  end
endmodule